// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that software drives through a small 32-bit register port. Words written to the transmit data offset queue in a transmit FIFO. A shift engine takes words from that FIFO, drives them onto the serial data output and captures the serial data input at the same time. Each captured word goes into a receive FIFO, which software drains by reading the receive data offset. The serial clock rate, the word width (8, 16 or 32 bits), the FIFO depth and the number of select lines (at most 16) are fixed by parameters when the block is built.

A typical transfer runs as follows. Software sets the hold bit, writes the slave-select register, and preloads the transmit FIFO. It then clears the hold bit and waits for the transmit FIFO to drain. Clock polarity, clock phase, LSB-first order and internal loopback are set from the control register. The select lines either track the slave-select register directly (manual mode) or are asserted only while a word is in flight (automatic mode).

The shift engine is a three-state machine. In ST_IDLE it waits until the block is enabled as master, not held, and has a queued word. It then pops that word and moves to ST_SHIFT. ST_SHIFT produces 2×W serial clock edges, one every HALF_DIV clock cycles, and moves to ST_DONE on the last edge. ST_DONE lasts one cycle, hands the received word to the receive FIFO, and returns to ST_IDLE.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register (offset 0x60) reads 0x100, the status register (offset 0x64) reads 0x05, every select line is high and the serial clock is low.
- R2: Control register bits are: 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 7 manual select, 8 hold (transmit inhibit), 9 LSB-first. A write to bits 0–4 and 7–9 reads back unchanged.
- R3: Control bits 5 (transmit FIFO clear) and 6 (receive FIFO clear) empty their FIFO when written as one and always read back as zero.
- R4: While the hold bit is set, no word leaves the transmit FIFO and the serial clock stays idle. Clearing the bit starts shifting the queued words in order.
- R5: Words are shifted only while both the enable bit and the master bit are set.
- R6: When no word is in flight, the serial clock rests at the clock polarity. With phase 0 the input is sampled on the leading edge of each clock pulse; with phase 1 it is sampled on the trailing edge. The output changes on the opposite edge. Words are MSB first by default.
- R7: With LSB-first set, bit 0 of each word is the first bit on the wire in both directions.
- R8: With loopback set, the serial output is routed internally to the sampling path. The received word then equals the transmitted word, and the external serial input has no effect.
- R9: In manual mode the select outputs equal the slave-select register (offset 0x70, active low) at all times.
- R10: In automatic mode all select outputs are high while idle. While a word is in flight they equal the slave-select register.
- R11: Status bits are: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full, 4 mode fault (always 0). Writing offset 0x68 queues a word. Reading offset 0x6C returns and removes the oldest received word.
- R12: When a word finishes while the receive FIFO is full, that word is dropped, the FIFO contents are kept, and the overrun output pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid in the following cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low select lines |
| rx_overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The bench acts as a serial slave. It runs eight single-word transfers covering the four polarity/phase combinations, each in MSB-first and LSB-first order. It checks the word seen on the wire and the word read back from the receive FIFO, so a sampling edge that is off by one edge, or a bit order that is reversed, shows up in one direction or the other. The slave's pattern differs from the transmit pattern, which tells loopback apart from the external input. Runs of several words exercise hold preloading, manual select held across words, the enable gate, and a fifth word arriving at a full receive FIFO. A per-clock model of the legal select values checks for select glitches.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } spim_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SEL  = 8'h70;

    localparam int CB_LOOP   = 0;
    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXCLR  = 5;
    localparam int CB_RXCLR  = 6;
    localparam int CB_MANUAL = 7;
    localparam int CB_HOLD   = 8;
    localparam int CB_LSB    = 9;

    localparam int          CTRL_W     = 10;
    localparam logic [9:0]  CTRL_RESET = 10'h100;
    localparam logic [9:0]  CTRL_CLRS  = 10'h060;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (clr) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp_q[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rp_q[AW-1:0]];
    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);   // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty);   // R11

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         have_word,
    input  logic [W-1:0] tx_word,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loop_en,
    input  logic         miso,
    output logic         take,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sck,
    output logic         mosi
);
    localparam int HW = $clog2(HALF_DIV) + 1;
    localparam int EW = $clog2(2 * W);
    localparam int BW = $clog2(W);

    spim_state_e  state_q, state_d;
    logic [HW-1:0] hcnt_q;
    logic [EW-1:0] ecnt_q;
    logic [BW-1:0] bit_q, pos;
    logic [W-1:0]  txw_q, rxw_q;
    logic          sck_q, tick, last, lead, sample_now, advance, din;

    assign tick       = (hcnt_q == HW'(HALF_DIV - 1));
    assign last       = (ecnt_q == EW'(2 * W - 1));
    assign lead       = ~ecnt_q[0];
    assign sample_now = (lead != cpha);
    assign advance    = cpha ? (lead && (ecnt_q != '0)) : (!lead && !last);
    assign pos        = lsb_first ? bit_q : (BW'(W - 1) - bit_q);
    assign mosi       = txw_q[pos];
    assign din        = loop_en ? mosi : miso;
    assign take       = (state_q == ST_IDLE) && go && have_word;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && have_word) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last)    state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            hcnt_q <= '0;
            ecnt_q <= '0;
            bit_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sck_q  <= cpol;
                    hcnt_q <= '0;
                    ecnt_q <= '0;
                    bit_q  <= '0;
                    if (take) txw_q <= tx_word;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        hcnt_q <= '0;
                        sck_q  <= ~sck_q;
                        ecnt_q <= ecnt_q + 1'b1;
                        if (sample_now) rxw_q[pos] <= din;
                        if (advance)    bit_q <= bit_q + 1'b1;
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign rx_word = rxw_q;
    assign sck     = (state_q == ST_SHIFT) ? sck_q : cpol;

    AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_SHIFT));   // R6

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEPTH    = 4,
    parameter int NSEL     = 4,
    parameter int HALF_DIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] ss_n,
    output logic            rx_overrun
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [NSEL-1:0]   sel_q;
    logic              wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop, rx_push;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              shf_take, shf_busy, shf_done, go;
    logic [W-1:0]      tx_head, rx_head, shf_rx;
    logic [31:0]       stat_w;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign tx_clr  = wr_ctrl && bus_wdata[CB_TXCLR];
    assign rx_clr  = wr_ctrl && bus_wdata[CB_RXCLR];
    assign tx_push = bus_wr && (bus_addr == OFS_TXD) && !tx_full;
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD) && !rx_empty;
    assign rx_push = shf_done && !rx_full;
    assign rx_overrun = shf_done && rx_full;
    assign go = ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ctrl_q[CB_HOLD];
    assign stat_w = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            sel_q  <= '1;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0] & ~CTRL_CLRS;
            if (bus_addr == OFS_SEL)  sel_q  <= bus_wdata[NSEL-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata <= 32'(ctrl_q);
                OFS_STAT: bus_rdata <= stat_w;
                OFS_RXD:  bus_rdata <= rx_empty ? 32'd0 : 32'(rx_head);
                OFS_SEL:  bus_rdata <= 32'(sel_q);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign ss_n = (ctrl_q[CB_MANUAL] || shf_busy) ? sel_q : '1;

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata[W-1:0]),
        .pop(shf_take), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(shf_rx),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

    spim_shifter #(.W(W), .HALF_DIV(HALF_DIV)) u_shf (
        .clk(clk), .rst_n(rst_n), .go(go), .have_word(!tx_empty), .tx_word(tx_head),
        .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]), .lsb_first(ctrl_q[CB_LSB]),
        .loop_en(ctrl_q[CB_LOOP]), .miso(miso), .take(shf_take), .busy(shf_busy),
        .done(shf_done), .rx_word(shf_rx), .sck(sck), .mosi(mosi));

    AST_HOLD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shf_busy && ctrl_q[CB_HOLD]) |=> !shf_busy);   // R4
    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_clr) |=> !rx_empty);   // R12
    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((sck != $past(sck)) && $stable(ctrl_q[CB_CPOL]) && !ctrl_q[CB_MANUAL])
        |-> (ss_n != '1));   // R10

endmodule

// File: tb/tb_spim_ctrl.sv
`timescale 1ns/1ps
module tb_spim_ctrl;
    localparam int W = 8;
    localparam int DEPTH = 4;
    localparam int NSEL = 4;
    localparam int HALF_DIV = 2;
    localparam int WORD_WAIT = 2 * W * HALF_DIV + 8;

    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                           A_RXD = 8'h6C, A_SEL = 8'h70;
    localparam int C_LOOP = 'h1, C_EN = 'h2, C_MST = 'h4, C_CPOL = 'h8, C_CPHA = 'h10,
                   C_TXR = 'h20, C_RXR = 'h40, C_MAN = 'h80, C_INH = 'h100, C_LSB = 'h200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic sck, mosi, miso = 1'b0, rx_overrun;
    logic [NSEL-1:0] ss_n;

    int checks = 0, errors = 0, ovr_cnt = 0;

    // bench-side model state
    bit m_cpha = 0, m_lsb = 0, m_manual = 0, cmp_on = 0;
    logic [NSEL-1:0] sel_m = '1;
    logic [W-1:0] s_tx[$];
    logic [W-1:0] s_got[$];
    logic sck_prev = 1'b0;
    int ecount = 0;
    logic [W-1:0] srx = '0;

    always #2 clk = ~clk;

    spim_ctrl #(.W(W), .DEPTH(DEPTH), .NSEL(NSEL), .HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .rx_overrun(rx_overrun));

    function automatic int bp(int n);
        return m_lsb ? n : (W - 1 - n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural serial slave
    always @(negedge clk) begin
        if (rst_n) begin
            if (&ss_n) begin
                ecount = 0;
            end else if (sck != sck_prev) begin
                if ((ecount % 2 == 0) != m_cpha) srx[bp(ecount / 2)] = mosi;
                ecount++;
                if (ecount == 2 * W) begin
                    s_got.push_back(srx);
                    if (s_tx.size() > 0) void'(s_tx.pop_front());
                    ecount = 0;
                end
            end
            sck_prev = sck;
            begin
                int n;
                logic [W-1:0] cur;
                n = m_cpha ? ((ecount == 0) ? 0 : (ecount - 1) / 2) : ecount / 2;
                cur = (s_tx.size() > 0) ? s_tx[0] : '0;
                miso = cur[bp(n)];
            end
        end
    end

    // per-clock comparison of select lines against the model (R9, R10)
    always @(negedge clk) begin
        if (rx_overrun) ovr_cnt++;
        if (cmp_on) begin
            checks++;
            if (m_manual ? (ss_n !== sel_m) : !((ss_n === '1) || (ss_n === sel_m))) begin
                errors++;
                $display("FAIL %s: actual ss_n %0h expected %0h", m_manual ? "R9" : "R10",
                         ss_n, sel_m);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [W-1:0] words[4];
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sck", 32'(sck), 32'h0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h100);
        rd(A_STAT, d); chk("R1 stat", d, 32'h05);

        // R2 readback, R3 clear bits read zero
        wr(A_CTRL, C_LOOP); rd(A_CTRL, d); chk("R2 loop readback", d, 32'h001);
        wr(A_CTRL, 'h3FF);  rd(A_CTRL, d); chk("R3 clear bits read zero", d, 32'h39F);
        wr(A_CTRL, C_INH | C_EN | C_MST);

        // R4 preload under hold, R11 flags
        sel_m = 4'hE; wr(A_SEL, 'hE); cmp_on = 1;
        wr(A_TXD, 'hA5); wr(A_TXD, 'h3C);
        idle(40);
        chk("R4 held ss_n", 32'(ss_n), 32'hF);
        rd(A_STAT, d); chk("R4 words held", d, 32'h01);
        wr(A_TXD, 'h11); wr(A_TXD, 'h22);
        rd(A_STAT, d); chk("R11 tx full", d, 32'h09);
        wr(A_CTRL, C_INH | C_EN | C_MST | C_TXR);
        rd(A_STAT, d); chk("R3 tx clear", d, 32'h05);

        // R6 / R7 all modes, both orders
        for (int i = 0; i < 8; i++) begin
            int base;
            logic [W-1:0] tw, sw;
            tw = W'(8'h5A ^ (i * 37));
            sw = W'(8'hC3 + i * 11);
            base = C_EN | C_MST | ((i % 4) >= 2 ? C_CPOL : 0) | ((i % 2) == 1 ? C_CPHA : 0) |
                   (i >= 4 ? C_LSB : 0);
            m_cpha = (i % 2) == 1; m_lsb = i >= 4;
            wr(A_CTRL, base | C_INH);
            idle(1);
            chk("R6 idle clock level", 32'(sck), ((i % 4) >= 2) ? 32'h1 : 32'h0);
            s_tx.push_back(sw);
            wr(A_TXD, 32'(tw));
            wr(A_CTRL, base);
            idle(10);
            if (i == 0) chk("R10 select during word", 32'(ss_n), 32'hE);
            idle(WORD_WAIT);
            rd(A_RXD, d); chk(m_lsb ? "R7 rx word" : "R6 rx word", d, 32'(sw));
            chk("R6 slave word count", s_got.size(), 1);
            if (s_got.size() > 0) chk(m_lsb ? "R7 wire word" : "R6 wire word",
                                      32'(s_got.pop_front()), 32'(tw));
            s_got.delete(); s_tx.delete();
        end

        // R8 loopback ignores the external input
        m_cpha = 0; m_lsb = 0;
        wr(A_CTRL, C_LOOP | C_EN | C_MST | C_INH);
        for (int k = 0; k < 3; k++) begin
            s_tx.push_back('1);
            wr(A_TXD, 'h31 + k * 'h22);
        end
        wr(A_CTRL, C_LOOP | C_EN | C_MST);
        idle(3 * WORD_WAIT);
        for (int k = 0; k < 3; k++) begin
            rd(A_RXD, d); chk("R8 loopback word", d, 32'('h31 + k * 'h22));
        end
        s_tx.delete(); s_got.delete();

        // R9 manual select across words
        cmp_on = 0;
        sel_m = 4'hF; wr(A_SEL, 'hF);
        wr(A_CTRL, C_MAN | C_EN | C_MST | C_INH);
        m_manual = 1;
        sel_m = 4'hB; wr(A_SEL, 'hB); cmp_on = 1;
        idle(4);
        chk("R9 idle select", 32'(ss_n), 32'hB);
        s_tx.push_back(8'h96); s_tx.push_back(8'h0F);
        wr(A_TXD, 'h12); wr(A_TXD, 'h34);
        wr(A_CTRL, C_MAN | C_EN | C_MST);
        idle(2 * WORD_WAIT);
        chk("R9 after words", 32'(ss_n), 32'hB);
        rd(A_RXD, d); chk("R9 first word", d, 32'h96);
        rd(A_RXD, d); chk("R9 second word", d, 32'h0F);
        cmp_on = 0;
        wr(A_CTRL, C_EN | C_MST | C_INH);
        m_manual = 0;
        sel_m = 4'hE; wr(A_SEL, 'hE); cmp_on = 1;
        s_tx.delete(); s_got.delete();

        // R11 / R12 receive full and overrun
        for (int k = 0; k < 4; k++) begin
            words[k] = W'('h40 + k);
            s_tx.push_back(words[k]);
            wr(A_TXD, k);
        end
        wr(A_CTRL, C_EN | C_MST);
        idle(4 * WORD_WAIT);
        rd(A_STAT, d); chk("R11 rx full", d, 32'h06);
        wr(A_CTRL, C_EN | C_MST | C_INH);
        ovr_cnt = 0;
        s_tx.push_back(8'hEE);
        wr(A_TXD, 'h77);
        wr(A_CTRL, C_EN | C_MST);
        idle(WORD_WAIT);
        chk("R12 overrun pulses", ovr_cnt, 1);
        for (int k = 0; k < 4; k++) begin
            rd(A_RXD, d); chk("R12 kept word", d, 32'(words[k]));
        end
        rd(A_STAT, d); chk("R12 dropped word absent", d, 32'h05);
        s_tx.delete(); s_got.delete();

        // R5 enable gate, then R3 receive clear
        wr(A_CTRL, C_MST);
        wr(A_TXD, 'h5C);
        idle(WORD_WAIT);
        rd(A_STAT, d); chk("R5 not enabled", d, 32'h01);
        wr(A_CTRL, C_EN | C_MST);
        idle(WORD_WAIT);
        rd(A_STAT, d); chk("R5 enabled", d, 32'h04);
        wr(A_CTRL, C_EN | C_MST | C_RXR);
        rd(A_STAT, d); chk("R3 rx clear", d, 32'h05);

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule